// File: doc/BRIEF.md
# Crystal Oscillator Failure Detector

This block watches a slow crystal clock. It uses a down counter that runs on a reference oscillator. The counter is loaded with a programmable top value and counts down one step per reference tick. When it reaches zero it reloads the top value, which closes one observation window. The crystal is sampled in the reference domain through a two-flop synchronizer, and its rising edges are detected there. If a window closes without any detected crystal edge, the block does two things. It raises a sticky failure interrupt flag. It also moves the real-time-clock source select over to the reference oscillator.

The choice between the two reference oscillators is made outside this block, so `clk_i` is always the reference that is currently selected. The block needs to know which one is in use because the first oscillator's ticks are divided by 2^(presc + lpcomp) before they reach the counter. The second oscillator steps the counter on every cycle. Detection runs only while the enable input is high.

Top module: `xtal_fail_det`

## Requirements
- R1: After reset, `fail_irq_o` is 0 and `clk_sel_ref_o` is 0 (0 = crystal source, 1 = reference source).
- R2: While `enable_i` is 0, the counter is held at `top_i`, the prescaler is cleared and the edge record is forced to "seen". No failure can be raised, and the first window after enabling never fails.
- R3: Each counter tick at a nonzero count decrements the count. A tick at count 0 is a zero event that reloads `top_i`. A window therefore spans `top_i`+1 ticks.
- R4: With `ref_sel_i` = 1 (second oscillator), the counter ticks on every enabled clock cycle.
- R5: With `ref_sel_i` = 0 (first oscillator), the counter ticks once every 2^(`presc_i`+`lpcomp_i`) enabled clock cycles. The tick falls on the last cycle of each group, counted from the cycle when enable rose.
- R6: At a zero event, if no synchronized rising edge of `xtal_i` has been recorded since the previous zero event, `fail_irq_o` and `clk_sel_ref_o` go to 1 on the following clock edge. A recorded edge prevents the failure.
- R7: A rising edge of `xtal_i` is detected when the second synchronizer stage shows 1 and a third register shows 0. An edge detected in the same cycle as a zero event counts toward the new window. A crystal edge must therefore reach the sampler at least two reference cycles before the zero event to count for the closing window.
- R8: `fail_irq_o` stays at 1 until `fail_clr_i` is 1 at a clock edge. When a new failure and a clear occur in the same cycle, the failure wins.
- R9: `clk_sel_ref_o` stays at 1 after a failure until reset. `fail_clr_i` has no effect on it.
- R10: A change of `top_i` while counting takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Selected reference oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Detection enable |
| ref_sel_i | input | 1 | 0: first oscillator (prescaled), 1: second oscillator |
| presc_i | input | 2 | Prescale exponent part |
| lpcomp_i | input | 1 | Additional prescale exponent part |
| top_i | input | 5 | Counter reload value |
| xtal_i | input | 1 | Crystal clock, asynchronous to clk_i |
| fail_clr_i | input | 1 | Write-1 clear of the failure flag |
| fail_irq_o | output | 1 | Sticky failure interrupt flag |
| clk_sel_ref_o | output | 1 | RTC clock select, 1 = reference source |

## Verification
Most internal errors show up as a change in the cycle when the failure flag rises. A wrong count or a wrong prescaler phase moves the zero events. A lost or stuck edge record creates a false failure or hides a real one. All of these appear at `fail_irq_o` within one window of the fault, at most 32×16 clock cycles. The bench runs a cycle-level model of windows, ticks and edges and compares both outputs on every clock. It uses crystal periods both shorter and longer than the window, stalled crystals, a top value changed mid-window and clears that collide with new failures.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_REF  = 1'b1
  } clk_src_e;

  function automatic int unsigned pre_width(input int unsigned pw, input int unsigned lw);
    return ((1 << pw) - 1) + ((1 << lw) - 1);
  endfunction
endpackage

// File: rtl/xfd_sync_edge.sv
module xfd_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic st1_q, st2_q, st3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
      st3_q <= 1'b0;
    end else begin
      st1_q <= async_i;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign rise_o = st2_q & ~st3_q;

  // R7: a detected edge is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xfd_tick_gen.sv
module xfd_tick_gen #(
  parameter int unsigned PRESC_W = 2,
  parameter int unsigned LPC_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               ref_sel_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [LPC_W-1:0]   lpcomp_i,
  output logic               tick_o
);
  localparam int unsigned PRE_W = xfd_pkg::pre_width(PRESC_W, LPC_W);
  localparam int unsigned EXP_W = $clog2(PRE_W + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [EXP_W-1:0] expo;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    expo  = EXP_W'(presc_i) + EXP_W'(lpcomp_i);
    span  = (PRE_W+1)'(1) << expo;
    mask  = PRE_W'(span - (PRE_W+1)'(1));
    pre_d = en_i ? pre_q + PRE_W'(1) : '0;
    tick_o = en_i & (ref_sel_i | ((pre_q & mask) == mask));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  // R5: the prescaler advances by one on every enabled cycle
  a_r5_pre_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> pre_q == $past(pre_q) + PRE_W'(1));
  // R2: the prescaler restarts from zero when disabled
  a_r2_pre_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pre_q == '0);
endmodule

// File: rtl/xfd_window.sv
module xfd_window #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] top_i,
  output logic             fail_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             zero_evt;

  always_comb begin
    zero_evt = tick_i & (cnt_q == '0);
    fail_o   = zero_evt & ~seen_q;
    cnt_d    = cnt_q;
    seen_d   = seen_q;
    if (!en_i) begin
      cnt_d  = top_i;
      seen_d = 1'b1;
    end else begin
      if (tick_i) cnt_d = zero_evt ? top_i : cnt_q - CNT_W'(1);
      seen_d = zero_evt ? rise_i : (seen_q | rise_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  // R3: reload at zero, decrement otherwise, hold without a tick
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q == '0) |=> cnt_q == $past(top_i));
  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r10_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
  // R2: idle keeps the count at top and the record set
  a_r2_idle_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == $past(top_i)) && seen_q);
endmodule

// File: rtl/xtal_fail_det.sv
module xtal_fail_det #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned PRESC_W = 2,
  parameter int unsigned LPC_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               ref_sel_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [LPC_W-1:0]   lpcomp_i,
  input  logic [CNT_W-1:0]   top_i,
  input  logic               xtal_i,
  input  logic               fail_clr_i,
  output logic               fail_irq_o,
  output logic               clk_sel_ref_o
);
  import xfd_pkg::*;

  logic rst_m_q, rst_s_q;
  logic rise, tick, fail_evt;
  logic irq_q, irq_d;
  clk_src_e src_q, src_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  xfd_sync_edge u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_s_q),
    .async_i(xtal_i),
    .rise_o (rise)
  );

  xfd_tick_gen #(.PRESC_W(PRESC_W), .LPC_W(LPC_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_s_q),
    .en_i     (enable_i),
    .ref_sel_i(ref_sel_i),
    .presc_i  (presc_i),
    .lpcomp_i (lpcomp_i),
    .tick_o   (tick)
  );

  xfd_window #(.CNT_W(CNT_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_s_q),
    .en_i  (enable_i),
    .tick_i(tick),
    .rise_i(rise),
    .top_i (top_i),
    .fail_o(fail_evt)
  );

  always_comb begin
    irq_d = fail_evt | (irq_q & ~fail_clr_i);
    src_d = (fail_evt || src_q == SRC_REF) ? SRC_REF : SRC_XTAL;
  end

  always_ff @(posedge clk_i or negedge rst_s_q) begin
    if (!rst_s_q) begin
      irq_q <= 1'b0;
      src_q <= SRC_XTAL;
    end else begin
      irq_q <= irq_d;
      src_q <= src_d;
    end
  end

  assign fail_irq_o    = irq_q;
  assign clk_sel_ref_o = (src_q == SRC_REF);

  // R8: flag stays set without a clear
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_s_q)
    (fail_irq_o && !fail_clr_i) |=> fail_irq_o);
  // R9: the source select never returns to the crystal
  a_r9_sel_latched: assert property (@(posedge clk_i) disable iff (!rst_s_q)
    clk_sel_ref_o |=> clk_sel_ref_o);
  // R6: a rising flag always comes with the reference source selected
  a_r6_flag_with_sel: assert property (@(posedge clk_i) disable iff (!rst_s_q)
    $rose(fail_irq_o) |-> clk_sel_ref_o);
endmodule

// File: tb/xtal_fail_det_tb_top.sv
module xtal_fail_det_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, rsel = 1'b1, xtal = 1'b0, clr = 1'b0;
  logic [1:0] presc = '0;
  logic [0:0] lpc = '0;
  logic [4:0] top = 5'd7;
  logic       irq, sel;

  int checks = 0, errors = 0, cycles = 0;
  string req = "R1";
  int xhalf = 0, xcnt = 0;

  always #4 clk = ~clk;

  xtal_fail_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .ref_sel_i(rsel),
    .presc_i(presc), .lpcomp_i(lpc), .top_i(top), .xtal_i(xtal),
    .fail_clr_i(clr), .fail_irq_o(irq), .clk_sel_ref_o(sel)
  );

  // behavioural reference
  int m_rs1, m_rs2, m_s1, m_s2, m_s3, m_cnt, m_pre, m_seen, m_fail, m_sel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_pre = 0; m_seen = 1; m_fail = 0; m_sel = 0;
    end else begin
      if (m_rs2 != 0) begin
        int rise_v, tick_v, zero_v, bad_v, grp;
        rise_v = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
        grp = 1 << (int'(presc) + int'(lpc));
        tick_v = (en && (rsel || (m_pre % grp) == grp - 1)) ? 1 : 0;
        zero_v = (tick_v == 1 && m_cnt == 0) ? 1 : 0;
        bad_v = (zero_v == 1 && m_seen == 0) ? 1 : 0;
        if (!en) begin
          m_cnt = int'(top); m_seen = 1; m_pre = 0;
        end else begin
          if (tick_v == 1) m_cnt = (m_cnt == 0) ? int'(top) : m_cnt - 1;
          m_seen = (zero_v == 1) ? rise_v : ((m_seen == 1 || rise_v == 1) ? 1 : 0);
          m_pre = (m_pre + 1) % 16;
        end
        m_fail = (bad_v == 1 || (m_fail == 1 && !clr)) ? 1 : 0;
        if (bad_v == 1) m_sel = 1;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(xtal);
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  task automatic check(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  // crystal stimulus and per-cycle comparison on the falling edge
  always @(negedge clk) begin
    cycles++;
    check(req, int'(irq), m_fail, "fail_irq");
    check(req, int'(sel), m_sel, "clk_sel");
    if (xhalf > 0) begin
      xcnt++;
      if (xcnt >= xhalf) begin xcnt = 0; xtal = ~xtal; end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; run(3); rst_n = 1'b1; run(3);
  endtask

  initial begin
    do_reset();
    req = "R1";
    check("R1", int'(irq), 0, "irq after reset");
    check("R1", int'(sel), 0, "sel after reset");

    // R2: disabled, stalled crystal, no failure
    req = "R2"; en = 0; xhalf = 0; run(200);
    check("R2", int'(irq), 0, "irq while disabled");

    // R4 R6: every-cycle ticks, fast crystal keeps healthy
    req = "R4"; rsel = 1; top = 7; xhalf = 2; en = 1; run(300);
    check("R4", int'(irq), 0, "no fail with fast crystal");

    // R5: prescaled, exponent 2, window 16 cycles, crystal period 8
    req = "R5"; en = 0; run(2); rsel = 0; presc = 1; lpc = 1; top = 3; xhalf = 4; en = 1; run(300);
    check("R5", int'(irq), 0, "no fail prescaled");

    // R6: crystal stalls -> failure and source switch
    req = "R6"; xhalf = 0; run(60);
    check("R6", int'(irq), 1, "fail after stall");
    check("R6", int'(sel), 1, "sel after stall");

    // R8: stays set; then clear
    req = "R8"; run(20);
    check("R8", int'(irq), 1, "sticky");
    clr = 1; run(1); clr = 0;
    req = "R9"; run(1);
    check("R9", int'(sel), 1, "sel unaffected by clear");
    req = "R8"; run(80);
    check("R8", int'(irq), 1, "refires while stalled");
    clr = 1; run(40); clr = 0; run(5);

    // R1 R9: only reset restores the crystal source
    do_reset(); req = "R9";
    check("R9", int'(sel), 0, "sel cleared by reset");

    // R10: long window first, then a short top mid-window
    req = "R10"; en = 0; rsel = 1; top = 31; xhalf = 12; run(2); en = 1; run(200);
    check("R10", int'(irq), 0, "window 32 vs period 24");
    top = 3; run(200);
    check("R10", int'(irq), 1, "short window fails");

    // R7: top 0 single-cycle windows, edge timing boundaries
    do_reset(); req = "R7"; en = 0; top = 0; xhalf = 1; run(2); en = 1; run(100);
    xhalf = 3; run(100);

    // R5 R3: largest prescale exponent, stalled crystal
    do_reset(); req = "R3"; en = 0; rsel = 0; presc = 3; lpc = 1; top = 1; xhalf = 0; run(2); en = 1; run(120);
    check("R3", int'(irq), 1, "fail with exponent 4");
    presc = 0; lpc = 0; top = 5; xhalf = 3; clr = 1; run(3); clr = 0; run(150);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule